// File: doc/BRIEF.md
# Switch Register Access Bridge

This block gives a host processor access to a switch's internal register space. That space is addressed by an 8-bit page and an 8-bit offset. The host sees a few 32-bit memory-mapped registers. It first sets an ownership request and waits until the grant bit reads back as one. It then loads the two halves of the 64-bit write data and writes a single command word. The command word carries the page, the offset, a direction flag and a go bit.

While the go bit is set, the bridge holds a request on a simple synchronous target bus. When the target answers with a ready pulse, the go bit clears. For a read, the 64-bit result is held in two read-data words. Transfers narrower than 64 bits only use the words, or parts of words, that software picks. The target bus always carries the full 64 bits.

Separately, a sticky capture register collects single-cycle event pulses from the switch: one per port, plus a PHY event, a time-sync event and three sleep-timer events. Software clears these bits by writing ones. The host interrupt line is raised when any captured bit is set and the interrupt enable is on.

Top module: `sw_reg_bridge`

## Requirements
- R1: After reset, the command word, control word, event word and read-data words all read zero. The interrupt output and the target request are low.
- R2: The control word lives at byte offset 0x40, with the request at bit 3 and the grant at bit 4. After bit 3 is written to one while no transfer is active, the grant reads one from the second clock edge onward. After bit 3 is cleared, the grant reads zero from the second clock edge onward.
- R3: A go write to the command word does not start a transfer and leaves go at zero in two cases: when the grant is not held, or while a transfer is already running. The page, offset and direction of the running transfer also stay unchanged.
- R4: The command word lives at offset 0x2C, with the page in bits 31:24, the offset in bits 23:16, the direction in bit 1 (1 = write) and go in bit 0. A granted go write raises the target request on the next clock edge. The target request then shows the page, offset and direction, and holds them steady until ready arrives.
- R5: A ready pulse during a transfer clears go (bit 0 of 0x2C reads back zero). For a read, the ready pulse also stores the target's 64-bit data: the upper half is read at 0x38 and the lower half at 0x3C. A ready pulse while idle changes nothing.
- R6: The target write data is the word at 0x30 (upper 32 bits) joined to the word at 0x34 (lower 32 bits). Both words read back as written.
- R7: Writing the command word with bit 2 set cancels any running transfer. It drops the target request, clears go and both read-data words, and bit 2 reads back zero. The bridge accepts new transfers afterwards.
- R8: At offset 0x44, an event pulse sets its bit and the bit stays set. Port events use bits 0 to 7, the PHY event bit 8, the time-sync event bit 9, and the sleep-timer events bits 10 to 12.
- R9: Writing ones to 0x44 clears those bits, and writing all ones clears every bit. If a pulse and a clear hit the same bit in the same cycle, the bit stays set.
- R10: The interrupt output is high exactly when bit 1 of 0x40 is one and at least one event bit is set.
- R11: Bit 6 of 0x40 follows the switch-initialisation-done input. Offsets that are not mapped read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_addr | input | 8 | Host byte offset for writes and reads |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| init_done | input | 1 | Switch initialisation finished |
| evt_pulse | input | NPORT+5 | Event pulses, one cycle each |
| irq | output | 1 | Host interrupt |
| tgt_req | output | 1 | Target access request, held until ready |
| tgt_we | output | 1 | Target access is a write |
| tgt_page | output | 8 | Target page |
| tgt_addr | output | 8 | Target offset within the page |
| tgt_wdata | output | 64 | Target write data |
| tgt_rdata | input | 64 | Target read data, valid with tgt_ready |
| tgt_ready | input | 1 | Target completion pulse |

## Verification
The properties assume three things about the environment. Host writes are single-cycle strobes with a stable offset. The target raises ready for one cycle per request, and tgt_rdata is valid in that same cycle. Event pulses may arrive in any cycle, including a cycle where software clears the same bit.

The bench's responder answers each request three cycles after it rises and returns data derived from the page and offset, so every read result can be told apart. One stray ready pulse while idle is injected on purpose. The bench also holds one request unanswered so the cancel path and the overlapping command can be exercised.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int HOST_W = 32;
  localparam int DATA_W = 2 * HOST_W;
  localparam int FLD_W  = 8;

  // host byte offsets (software decodes these)
  localparam logic [7:0] OFS_CMD = 8'h2C;
  localparam logic [7:0] OFS_WHI = 8'h30;
  localparam logic [7:0] OFS_WLO = 8'h34;
  localparam logic [7:0] OFS_RHI = 8'h38;
  localparam logic [7:0] OFS_RLO = 8'h3C;
  localparam logic [7:0] OFS_CTL = 8'h40;
  localparam logic [7:0] OFS_EVT = 8'h44;

  // command word fields
  localparam int CMD_GO     = 0;
  localparam int CMD_WE     = 1;
  localparam int CMD_CANCEL = 2;
  localparam int CMD_OFF_LO = 16;
  localparam int CMD_PG_LO  = 24;

  // control word fields
  localparam int CTL_IEN  = 1;
  localparam int CTL_REQ  = 3;
  localparam int CTL_GNT  = 4;
  localparam int CTL_INIT = 6;

  typedef struct packed {
    logic [FLD_W-1:0] page;
    logic [FLD_W-1:0] off;
    logic             we;
  } xfer_t;

  function automatic xfer_t cmd_decode(logic [HOST_W-1:0] w);
    xfer_t x;
    x.page = w[CMD_PG_LO +: FLD_W];
    x.off  = w[CMD_OFF_LO +: FLD_W];
    x.we   = w[CMD_WE];
    return x;
  endfunction

  function automatic logic [HOST_W-1:0] cmd_encode(xfer_t x, logic go);
    logic [HOST_W-1:0] w;
    w = '0;
    w[CMD_PG_LO +: FLD_W]  = x.page;
    w[CMD_OFF_LO +: FLD_W] = x.off;
    w[CMD_WE]              = x.we;
    w[CMD_GO]              = go;
    return w;
  endfunction

  function automatic logic [HOST_W-1:0] ctl_encode(logic ien, logic req, logic gnt, logic init);
    logic [HOST_W-1:0] w;
    w = '0;
    w[CTL_IEN]  = ien;
    w[CTL_REQ]  = req;
    w[CTL_GNT]  = gnt;
    w[CTL_INIT] = init;
    return w;
  endfunction

  // sticky capture step: clear first, then fresh pulses win
  function automatic logic [HOST_W-1:0] sticky_next(logic [HOST_W-1:0] cur,
                                                    logic [HOST_W-1:0] clr,
                                                    logic [HOST_W-1:0] pulse);
    return (cur & ~clr) | pulse;
  endfunction
endpackage

// File: rtl/srb_grant.sv
module srb_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic busy,
  output logic gnt
);
  // grant is given only from idle, kept while request stays set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt <= 1'b0;
    else        gnt <= req & (gnt | ~busy);
  end
endmodule

// File: rtl/srb_engine.sv
module srb_engine
  import srb_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cancel,
  input  xfer_t         new_x,
  input  logic          tgt_ready,
  input  logic [DW-1:0] tgt_rdata,
  output logic          busy,
  output logic          done,
  output xfer_t         cur_x,
  output logic [DW-1:0] rd_q
);
  assign done = busy & tgt_ready & ~cancel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cur_x <= '0;
      rd_q  <= '0;
    end else if (cancel) begin
      busy <= 1'b0;
      rd_q <= '0;
    end else if (done) begin
      busy <= 1'b0;
      if (!cur_x.we) rd_q <= tgt_rdata;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cur_x <= new_x;
    end
  end
endmodule

// File: rtl/srb_evt_cap.sv
module srb_evt_cap
  import srb_pkg::*;
#(
  parameter int EVW = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [EVW-1:0] pulse,
  input  logic           clr_en,
  input  logic [EVW-1:0] clr_mask,
  output logic [EVW-1:0] cap
);
  logic [HOST_W-1:0] nxt;

  always_comb begin
    nxt = sticky_next(HOST_W'(cap), clr_en ? HOST_W'(clr_mask) : '0, HOST_W'(pulse));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap <= '0;
    else        cap <= nxt[EVW-1:0];
  end
endmodule

// File: rtl/sw_reg_bridge.sv
module sw_reg_bridge
  import srb_pkg::*;
#(
  parameter  int NPORT = 8,
  localparam int EVW   = NPORT + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [7:0]        host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              init_done,
  input  logic [EVW-1:0]    evt_pulse,
  output logic              irq,
  output logic              tgt_req,
  output logic              tgt_we,
  output logic [FLD_W-1:0]  tgt_page,
  output logic [FLD_W-1:0]  tgt_addr,
  output logic [DATA_W-1:0] tgt_wdata,
  input  logic [DATA_W-1:0] tgt_rdata,
  input  logic              tgt_ready
);
  // named internal events
  logic              wr_cmd, wr_ctl, wr_evt;
  logic              cmd_go_wr, cmd_cancel, cmd_start, cmd_done;
  logic              busy, gnt;
  logic              ctl_req, irq_en;
  logic [HOST_W-1:0] wd_hi, wd_lo;
  logic [DATA_W-1:0] rd_q;
  logic [EVW-1:0]    cap;
  xfer_t             cur_x;

  assign wr_cmd     = host_wr && (host_addr == OFS_CMD);
  assign wr_ctl     = host_wr && (host_addr == OFS_CTL);
  assign wr_evt     = host_wr && (host_addr == OFS_EVT);
  assign cmd_cancel = wr_cmd && host_wdata[CMD_CANCEL];
  assign cmd_go_wr  = wr_cmd && host_wdata[CMD_GO] && !host_wdata[CMD_CANCEL];
  assign cmd_start  = cmd_go_wr && gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_req <= 1'b0;
      irq_en  <= 1'b0;
      wd_hi   <= '0;
      wd_lo   <= '0;
    end else if (host_wr) begin
      if (wr_ctl) begin
        ctl_req <= host_wdata[CTL_REQ];
        irq_en  <= host_wdata[CTL_IEN];
      end
      if (host_addr == OFS_WHI) wd_hi <= host_wdata;
      if (host_addr == OFS_WLO) wd_lo <= host_wdata;
    end
  end

  srb_grant u_grant (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (ctl_req),
    .busy (busy),
    .gnt  (gnt)
  );

  srb_engine #(.DW(DATA_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cmd_start),
    .cancel   (cmd_cancel),
    .new_x    (cmd_decode(host_wdata)),
    .tgt_ready(tgt_ready),
    .tgt_rdata(tgt_rdata),
    .busy     (busy),
    .done     (cmd_done),
    .cur_x    (cur_x),
    .rd_q     (rd_q)
  );

  srb_evt_cap #(.EVW(EVW)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse   (evt_pulse),
    .clr_en  (wr_evt),
    .clr_mask(host_wdata[EVW-1:0]),
    .cap     (cap)
  );

  assign tgt_req   = busy;
  assign tgt_we    = cur_x.we;
  assign tgt_page  = cur_x.page;
  assign tgt_addr  = cur_x.off;
  assign tgt_wdata = {wd_hi, wd_lo};
  assign irq       = irq_en & (|cap);

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      OFS_CMD: host_rdata = cmd_encode(cur_x, busy);
      OFS_WHI: host_rdata = wd_hi;
      OFS_WLO: host_rdata = wd_lo;
      OFS_RHI: host_rdata = rd_q[DATA_W-1:HOST_W];
      OFS_RLO: host_rdata = rd_q[HOST_W-1:0];
      OFS_CTL: host_rdata = ctl_encode(irq_en, ctl_req, gnt, init_done);
      OFS_EVT: host_rdata[EVW-1:0] = cap;
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/srb_chk.sv
module srb_chk #(
  parameter int EVW = 13
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ctl_req,
  input logic           gnt,
  input logic           busy,
  input logic           cmd_go_wr,
  input logic           cmd_cancel,
  input logic           tgt_ready,
  input logic           tgt_we,
  input logic [7:0]     tgt_page,
  input logic [7:0]     tgt_addr,
  input logic [63:0]    rd_q,
  input logic [EVW-1:0] evt_pulse,
  input logic [EVW-1:0] cap
);
  // R2
  gnt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_req |=> !gnt);

  // R2
  gnt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt) |-> ($past(ctl_req) && !$past(busy)));

  // R3
  nogrant_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go_wr && !gnt && !busy) |=> !busy);

  // R4
  tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tgt_ready && !cmd_cancel) |=>
      (busy && $stable(tgt_page) && $stable(tgt_addr) && $stable(tgt_we)));

  // R5
  ready_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tgt_ready && !cmd_cancel) |=> !busy);

  // R7
  cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cancel |=> (!busy && rd_q == '0));

  // R9
  pulse_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((cap & $past(evt_pulse)) == $past(evt_pulse)));
endmodule

bind sw_reg_bridge srb_chk #(.EVW(EVW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_req   (ctl_req),
  .gnt       (gnt),
  .busy      (busy),
  .cmd_go_wr (cmd_go_wr),
  .cmd_cancel(cmd_cancel),
  .tgt_ready (tgt_ready),
  .tgt_we    (tgt_we),
  .tgt_page  (tgt_page),
  .tgt_addr  (tgt_addr),
  .rd_q      (rd_q),
  .evt_pulse (evt_pulse),
  .cap       (cap)
);

// File: tb/sw_reg_bridge_tb.sv
`timescale 1ns/1ps
module sw_reg_bridge_tb;
  localparam int EV = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_addr = 8'h00;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        init_done = 1'b0;
  logic [EV-1:0] evt_pulse = '0;
  logic        irq, tgt_req, tgt_we;
  logic [7:0]  tgt_page, tgt_addr;
  logic [63:0] tgt_wdata, tgt_rdata;
  logic        tgt_ready;
  logic        resp_rdy = 1'b0, stray_rdy = 1'b0, resp_hold = 1'b0;
  int          resp_cnt = 0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  sw_reg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .init_done(init_done),
    .evt_pulse(evt_pulse), .irq(irq), .tgt_req(tgt_req), .tgt_we(tgt_we),
    .tgt_page(tgt_page), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
    .tgt_rdata(tgt_rdata), .tgt_ready(tgt_ready)
  );

  function automatic logic [63:0] pattern(logic [7:0] p, logic [7:0] o);
    return {p, o, 16'hC0DE, ~p, ~o, 16'h5A5A};
  endfunction

  assign tgt_rdata = pattern(tgt_page, tgt_addr);
  assign tgt_ready = resp_rdy | stray_rdy;

  // target responder: ready three cycles into a request
  always @(negedge clk) begin
    if (resp_rdy) begin
      resp_rdy = 1'b0;
      resp_cnt = 0;
    end else if (tgt_req && !resp_hold) begin
      resp_cnt++;
      if (resp_cnt >= 3) resp_rdy = 1'b1;
    end else resp_cnt = 0;
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_req, m_ien, m_gnt, m_go, m_we;
  int          m_pg, m_of;
  logic [31:0] m_wh, m_wl;
  logic [63:0] m_rd;
  logic [EV-1:0] m_cap;
  bit          nx_gnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = 0; m_ien = 0; m_gnt = 0; m_go = 0; m_we = 0;
      m_pg = 0; m_of = 0; m_wh = 0; m_wl = 0; m_rd = 0; m_cap = 0;
    end else begin
      nx_gnt = m_req && (m_gnt || !m_go);
      if (host_wr && host_addr == 8'h2C && host_wdata[2]) begin
        m_go = 0; m_rd = 0;
      end else if (m_go && tgt_ready) begin
        m_go = 0;
        if (!m_we) m_rd = tgt_rdata;
      end else if (host_wr && host_addr == 8'h2C && host_wdata[0] && m_gnt && !m_go) begin
        m_go = 1;
        m_pg = int'(host_wdata >> 24);
        m_of = int'((host_wdata >> 16) & 32'hFF);
        m_we = host_wdata[1];
      end
      if (host_wr && host_addr == 8'h40) begin
        m_req = host_wdata[3];
        m_ien = host_wdata[1];
      end
      if (host_wr && host_addr == 8'h30) m_wh = host_wdata;
      if (host_wr && host_addr == 8'h34) m_wl = host_wdata;
      for (int b = 0; b < EV; b++) begin
        if (host_wr && host_addr == 8'h44 && host_wdata[b]) m_cap[b] = 1'b0;
        if (evt_pulse[b]) m_cap[b] = 1'b1;
      end
      m_gnt = nx_gnt;
    end
  end

  function automatic logic [31:0] model_read(logic [7:0] a);
    logic [31:0] v;
    v = 0;
    if (a == 8'h2C) v = (m_pg << 24) | (m_of << 16) | (m_we ? 2 : 0) | (m_go ? 1 : 0);
    else if (a == 8'h30) v = m_wh;
    else if (a == 8'h34) v = m_wl;
    else if (a == 8'h38) v = m_rd[63:32];
    else if (a == 8'h3C) v = m_rd[31:0];
    else if (a == 8'h40) v = (init_done ? 64 : 0) | (m_gnt ? 16 : 0) | (m_req ? 8 : 0) | (m_ien ? 2 : 0);
    else if (a == 8'h44) v = 32'(m_cap);
    return v;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h2C: return "R4";
      8'h30, 8'h34: return "R6";
      8'h38, 8'h3C: return "R5";
      8'h40: return "R2";
      8'h44: return "R8";
      default: return "R11";
    endcase
  endfunction

  // compare against the model on every clock, away from the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      chk(tag_of(host_addr), "readback", 64'(host_rdata), 64'(model_read(host_addr)));
      chk("R10", "irq", 64'(irq), 64'(m_ien && (m_cap != 0)));
      chk("R4", "tgt_req", 64'(tgt_req), 64'(m_go));
      if (m_go) chk("R4", "tgt fields", {tgt_page, tgt_addr, 7'd0, tgt_we},
                    64'({m_pg[7:0], m_of[7:0], 7'd0, m_we}));
      chk("R6", "tgt_wdata", tgt_wdata, {m_wh, m_wl});
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    host_addr = a;
    #1;
    v = host_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50; i++) begin
      if (!tgt_req) break;
      @(negedge clk);
    end
  endtask

  task automatic pulse(input logic [EV-1:0] m);
    @(negedge clk); evt_pulse = m;
    @(negedge clk); evt_pulse = '0;
  endtask

  logic [31:0] v;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    init_done = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h2C, v); chk("R1", "cmd after reset", 64'(v), 64'h0);
    rd(8'h3C, v); chk("R1", "rd lo after reset", 64'(v), 64'h0);
    rd(8'h44, v); chk("R1", "events after reset", 64'(v), 64'h0);
    chk("R1", "irq/tgt_req after reset", {irq, tgt_req}, 64'h0);

    // R3 command without grant
    hw(8'h2C, 32'h1234_0001);
    chk("R3", "tgt_req without grant", 64'(tgt_req), 64'h0);
    rd(8'h2C, v); chk("R3", "go without grant", 64'(v[0]), 64'h0);

    // R2 grant one cycle after request
    hw(8'h40, 32'h0000_0008);
    rd(8'h40, v); chk("R2", "grant not yet", 64'(v[4]), 64'h0);
    @(negedge clk);
    rd(8'h40, v); chk("R2", "grant up", 64'(v[4]), 64'h1);

    // R6 write data
    hw(8'h30, 32'hDEAD_BEEF);
    hw(8'h34, 32'h0123_4567);
    chk("R6", "tgt_wdata", tgt_wdata, 64'hDEADBEEF_01234567);

    // R4 target write
    hw(8'h2C, 32'hA53C_0003);
    chk("R4", "write request", {tgt_req, tgt_we, tgt_page, tgt_addr}, {2'b11, 8'hA5, 8'h3C});
    wait_idle();
    rd(8'h2C, v); chk("R5", "go cleared after write", 64'(v), 64'hA53C_0002);

    // R5 target read
    hw(8'h2C, 32'h0710_0001);
    chk("R4", "read request", {tgt_req, tgt_we, tgt_page, tgt_addr}, {2'b10, 8'h07, 8'h10});
    wait_idle();
    rd(8'h38, v); chk("R5", "read hi", 64'(v), 64'h0710_C0DE);
    rd(8'h3C, v); chk("R5", "read lo", 64'(v), 64'hF8EF_5A5A);

    // R3 busy command ignored, R7 cancel
    resp_hold = 1'b1;
    hw(8'h2C, 32'h0111_0001);
    hw(8'h2C, 32'h0222_0001);
    chk("R3", "busy command ignored", {tgt_req, tgt_page, tgt_addr}, {1'b1, 8'h01, 8'h11});
    hw(8'h2C, 32'h0000_0004);
    chk("R7", "cancel drops request", 64'(tgt_req), 64'h0);
    rd(8'h2C, v); chk("R7", "go and cancel bits", 64'(v[2:0]), 64'h0);
    rd(8'h38, v); chk("R7", "read hi cleared", 64'(v), 64'h0);
    resp_hold = 1'b0;

    // R5 stray ready while idle
    @(negedge clk); stray_rdy = 1'b1;
    @(negedge clk); stray_rdy = 1'b0;
    rd(8'h3C, v); chk("R5", "stray ready ignored", 64'(v), 64'h0);

    // R7 usable after cancel
    hw(8'h2C, 32'h0311_0001);
    wait_idle();
    rd(8'h38, v); chk("R7", "read after cancel hi", 64'(v), 64'h0311_C0DE);
    rd(8'h3C, v); chk("R7", "read after cancel lo", 64'(v), 64'hFCEE_5A5A);

    // R2 release
    hw(8'h40, 32'h0000_0000);
    @(negedge clk);
    rd(8'h40, v); chk("R2", "grant dropped", 64'(v[4]), 64'h0);
    hw(8'h2C, 32'h0444_0001);
    chk("R3", "command after release", 64'(tgt_req), 64'h0);

    // R8 events, R10 interrupt
    pulse(13'h1108);
    rd(8'h44, v); chk("R8", "captured bits", 64'(v), 64'h1108);
    chk("R10", "irq disabled", 64'(irq), 64'h0);
    hw(8'h40, 32'h0000_0002);
    chk("R10", "irq enabled", 64'(irq), 64'h1);
    hw(8'h44, 32'h0000_0100);
    rd(8'h44, v); chk("R9", "w1c one bit", 64'(v), 64'h1008);

    // R9 pulse beats clear in the same cycle
    @(negedge clk);
    host_wr = 1'b1; host_addr = 8'h44; host_wdata = 32'h0000_1008; evt_pulse = 13'h0008;
    @(negedge clk);
    host_wr = 1'b0; evt_pulse = '0;
    rd(8'h44, v); chk("R9", "pulse wins", 64'(v), 64'h0008);
    hw(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, v); chk("R9", "clear all", 64'(v), 64'h0);
    chk("R10", "irq after clear", 64'(irq), 64'h0);

    // R11 init flag and unmapped offsets
    rd(8'h40, v); chk("R11", "init flag set", 64'(v[6]), 64'h1);
    init_done = 1'b0;
    rd(8'h40, v); chk("R11", "init flag clear", 64'(v[6]), 64'h0);
    rd(8'h00, v); chk("R11", "unmapped 0x00", 64'(v), 64'h0);
    rd(8'h48, v); chk("R11", "unmapped 0x48", 64'(v), 64'h0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule